// File: doc/BRIEF.md
# GPIO Interrupt Latch and Summary

This block watches a set of general-purpose input pins and turns activity on them into one interrupt request for a processor. Each pin first goes through a multi-flop synchronizer. A per-pin detector then looks for either a steady level or a transition, and the polarity is selectable. A detected event is held in a sticky per-pin status flag. All flags that are allowed through are OR-reduced into one registered summary line.

Each pin has two independent gates. The capture gate decides whether the detector may set the status flag at all. The report gate decides only whether a set flag reaches the summary line. Software that masks a level-sensitive pin therefore closes the capture gate as well. If it does not, the still-present level keeps setting the flag again after every acknowledge. An edge-sensitive pin can keep its capture gate open while it is masked, so a transition that arrives during the mask is held and reported later.

Configuration and status are reached through a small register port. Writes take effect on the clock edge. Read data comes out of a register one cycle after the address is presented.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset every status flag, capture gate and report gate is clear, every configuration and status word reads 0, and `irq_out` is low.
- R2: While a pin's capture gate (configuration bit 0) is 0, its status flag never sets, whatever the pin does.
- R3: `irq_out` reflects only flags whose report gate (configuration bit 1) is 1. Clearing the report gate alone does not stop capture: a flag still sets and reads back as 1.
- R4: Trigger field (configuration bits 3:2) 00 means active-high level and 01 means active-low level. While the active level persists with capture enabled, an acknowledged flag sets again.
- R5: Trigger field 10 means rising edge and 11 means falling edge. An edge caught while the report gate is 0 stays pending and raises `irq_out` once the report gate is set. A held level after the edge does not set the flag again after an acknowledge.
- R6: A status flag stays set after the pin returns to its inactive state. It clears only when software writes 1 to bit 0 of that pin's status word; writing 0 has no effect.
- R7: When an acknowledge and a qualifying event fall in the same cycle, the flag stays set and `irq_out` does not drop.
- R8: Writing the capture gate or the trigger field while the pin input is steady does not by itself set an edge-type flag.
- R9: A pin change sets its flag on the third rising clock edge after it is applied (two synchronizer stages plus the flag). `irq_out` rises one edge later, and it falls one edge after the last contributing flag clears.
- R10: `reg_addr` bit 0 selects the configuration word (0) or the status word (1), and the upper address bits give the pin index. Configuration bits above bit 3 read as 0, and the status word uses only bit 0. A pin index at or above `NUM_PINS` reads 0 and ignores writes. `reg_rdata` is registered and shows the addressed word one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+1 | Word address: {pin index, word select} |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
The bench builds the block with `NUM_PINS` = 6, `DATA_W` = 32 and `SYNC_STAGES` = 2. The pin count is deliberately not a power of two. The 4-bit address then decodes indices 6 and 7, which have no channel, so the rule that out-of-range reads return 0 and out-of-range writes are ignored is exercised by both the directed and the random traffic. With two synchronizer stages, the exact edge on which a flag sets and `irq_out` follows can be checked against a fixed cycle count. The random phase mixes pin toggles with writes to every address, so acknowledges land on the same cycle as new events and configuration changes land next to edges.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   typedef enum logic [1:0] {
      TRIG_HIGH = 2'b00,
      TRIG_LOW  = 2'b01,
      TRIG_RISE = 2'b10,
      TRIG_FALL = 2'b11
   } trig_e;

   // Packed so that latch_en is bit 0, fwd_en bit 1, trig bits 3:2
   typedef struct packed {
      trig_e trig;
      logic  fwd_en;
      logic  latch_en;
   } pin_cfg_t;

   localparam int CFG_W = $bits(pin_cfg_t);

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan
   import gpio_irq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sync_in,
   input  logic     cfg_we,
   input  pin_cfg_t cfg_wdata,
   input  logic     ack,
   output pin_cfg_t cfg_q,
   output logic     status_q
);

   logic prev_q;
   logic hit;
   logic evt;

   // The previous sample follows the synchronized input on every cycle, so
   // an enable or trigger change always compares two genuine samples.
   always_comb begin
      unique case (cfg_q.trig)
         TRIG_HIGH: hit = sync_in;
         TRIG_LOW:  hit = ~sync_in;
         TRIG_RISE: hit = sync_in & ~prev_q;
         TRIG_FALL: hit = ~sync_in & prev_q;
         default:   hit = 1'b0;
      endcase
   end

   assign evt = cfg_q.latch_en & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= 1'b0;
         cfg_q    <= '0;
         status_q <= 1'b0;
      end else begin
         prev_q   <= sync_in;
         status_q <= (status_q & ~ack) | evt;
         if (cfg_we) cfg_q <= cfg_wdata;
      end
   end

endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] status,
   input  logic [N-1:0] enable,
   output logic         irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(status & enable);
   end

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
   import gpio_irq_pkg::*;
#(
   parameter  int NUM_PINS    = 8,
   parameter  int DATA_W      = 32,
   parameter  int SYNC_STAGES = 2,
   localparam int IDX_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
   localparam int ADDR_W      = IDX_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                irq_out
);

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("gpio_irq_agg: NUM_PINS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_irq_agg: SYNC_STAGES must be at least 2");
   end
   if (DATA_W < CFG_W) begin : g_bad_data
      $error("gpio_irq_agg: DATA_W must hold a configuration word");
   end

   logic [NUM_PINS-1:0] sync_vec;
   logic [NUM_PINS-1:0] st_vec;
   logic [NUM_PINS-1:0] le_vec;
   logic [NUM_PINS-1:0] fwd_vec;
   logic [NUM_PINS-1:0] clr_vec;
   logic [NUM_PINS-1:0] cfg_we_vec;
   pin_cfg_t            cfg_arr [NUM_PINS];
   pin_cfg_t            cfg_wdata;

   logic [IDX_W-1:0]    sel_idx;
   logic                sel_status;
   logic                idx_ok;
   logic [DATA_W-1:0]   rd_next;

   assign sel_idx    = reg_addr[ADDR_W-1:1];
   assign sel_status = reg_addr[0];
   assign idx_ok     = ({1'b0, sel_idx} < (IDX_W+1)'(NUM_PINS));
   assign cfg_wdata  = pin_cfg_t'(reg_wdata[CFG_W-1:0]);

   gpio_irq_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (sync_vec)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign cfg_we_vec[p] = reg_wr & ~sel_status & idx_ok &
                             (sel_idx == IDX_W'(p));
      assign clr_vec[p]    = reg_wr & sel_status & idx_ok &
                             (sel_idx == IDX_W'(p)) & reg_wdata[0];

      gpio_irq_chan u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .sync_in   (sync_vec[p]),
         .cfg_we    (cfg_we_vec[p]),
         .cfg_wdata (cfg_wdata),
         .ack       (clr_vec[p]),
         .cfg_q     (cfg_arr[p]),
         .status_q  (st_vec[p])
      );

      assign le_vec[p]  = cfg_arr[p].latch_en;
      assign fwd_vec[p] = cfg_arr[p].fwd_en;
   end

   gpio_irq_summary #(
      .N (NUM_PINS)
   ) u_summary (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (st_vec),
      .enable (fwd_vec),
      .irq    (irq_out)
   );

   always_comb begin
      rd_next = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (idx_ok && sel_idx == IDX_W'(p)) begin
            if (sel_status) rd_next[0]         = st_vec[p];
            else            rd_next[CFG_W-1:0] = cfg_arr[p];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_rdata <= '0;
      else        reg_rdata <= rd_next;
   end

endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk #(
   parameter int NUM_PINS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                irq_out,
   input logic [NUM_PINS-1:0] st_vec,
   input logic [NUM_PINS-1:0] le_vec,
   input logic [NUM_PINS-1:0] fwd_vec,
   input logic [NUM_PINS-1:0] clr_vec
);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
      // R2: a flag can only rise if its capture gate was open
      a_r2_latch_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(st_vec[p]) |-> $past(le_vec[p]));

      // R6: a flag only falls after a write-1 acknowledge
      a_r6_sticky_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(st_vec[p]) |-> $past(clr_vec[p]));
   end

   // R3: the summary line only rises when a reported flag was pending
   a_r3_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> $past(|(st_vec & fwd_vec)));

   // R9: the summary line only falls once no reported flag was pending
   a_r9_irq_falls_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_out) |-> $past(~|(st_vec & fwd_vec)));

endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(
   .NUM_PINS (NUM_PINS)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_out (irq_out),
   .st_vec  (st_vec),
   .le_vec  (le_vec),
   .fwd_vec (fwd_vec),
   .clr_vec (clr_vec)
);

// File: tb/gpio_irq_agg_tb.sv
`timescale 1ns/1ps
module gpio_irq_agg_tb;

   localparam int NP = 6;
   localparam int AW = 4;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NP-1:0] pin_in;
   logic          reg_wr;
   logic [AW-1:0] reg_addr;
   logic [DW-1:0] reg_wdata;
   logic [DW-1:0] reg_rdata;
   logic          irq_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   gpio_irq_agg #(
      .NUM_PINS    (NP),
      .DATA_W      (DW),
      .SYNC_STAGES (2)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_in    (pin_in),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_out   (irq_out)
   );

   // Reference model built from the requirements
   logic [NP-1:0] m_s1, m_s2, m_prev, m_st, m_le, m_fwd;
   logic [1:0]    m_trig [NP];
   logic          m_irq;
   logic [DW-1:0] m_rd;

   function automatic logic m_hit(input logic [1:0] t, input logic s, input logic pv);
      case (t)
         2'b00:   return s;
         2'b01:   return ~s;
         2'b10:   return s & ~pv;
         default: return ~s & pv;
      endcase
   endfunction

   function automatic logic [DW-1:0] m_read(input logic [AW-1:0] a);
      logic [DW-1:0] r = '0;
      int idx = int'(a[AW-1:1]);
      if (idx < NP) begin
         if (a[0]) r[0] = m_st[idx];
         else      r[3:0] = {m_trig[idx], m_fwd[idx], m_le[idx]};
      end
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_st <= '0;
         m_le <= '0; m_fwd <= '0; m_irq <= 1'b0; m_rd <= '0;
         for (int p = 0; p < NP; p++) m_trig[p] <= 2'b00;
      end else begin
         for (int p = 0; p < NP; p++) begin
            logic clr;
            clr = reg_wr && reg_addr == AW'(2*p+1) && reg_wdata[0];
            m_st[p] <= (m_st[p] & ~clr) | (m_le[p] & m_hit(m_trig[p], m_s2[p], m_prev[p]));
            if (reg_wr && reg_addr == AW'(2*p)) begin
               m_le[p]   <= reg_wdata[0];
               m_fwd[p]  <= reg_wdata[1];
               m_trig[p] <= reg_wdata[3:2];
            end
         end
         m_s1   <= pin_in;
         m_s2   <= m_s1;
         m_prev <= m_s2;
         m_irq  <= |(m_st & m_fwd);
         m_rd   <= m_read(reg_addr);
      end
   end

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input int a, output logic [DW-1:0] d);
      reg_addr = AW'(a);
      @(negedge clk);
      d = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [DW-1:0] v;
      void'($urandom(32'h1357_2468));
      rst_n = 1'b0; pin_in = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      chk("R1 irq", irq_out, 0);
      rd(0, v);  chk("R1 cfg0", v, 0);
      rd(1, v);  chk("R1 st0", v, 0);
      rd(10, v); chk("R1 cfg5", v, 0);

      // R2 capture gate closed: no latch
      pin_in[5] = 1'b1;
      wr(10, 32'h2);
      idle(5);
      rd(11, v); chk("R2 st5", v, 0);
      chk("R2 irq", irq_out, 0);
      wr(10, 0); pin_in[5] = 1'b0; idle(3);

      // R9 latency on pin0, active-high level
      wr(0, 32'h3);
      idle(2);
      pin_in[0] = 1'b1;
      idle(3); chk("R9 irq before", irq_out, 0);
      idle(1); chk("R9 irq after", irq_out, 1);

      // R4 / R7 acknowledge while level present
      wr(1, 1);
      chk("R7 irq hold a", irq_out, 1);
      idle(1); chk("R7 irq hold b", irq_out, 1);
      rd(1, v); chk("R4 relatch", v, 1);

      // R6 sticky after deassert, write 0 has no effect
      pin_in[0] = 1'b0;
      idle(4);
      rd(1, v); chk("R6 sticky", v, 1);
      wr(1, 0);
      rd(1, v); chk("R6 write0", v, 1);
      wr(1, 1);
      chk("R9 fall late", irq_out, 1);
      idle(1); chk("R9 fall", irq_out, 0);
      rd(1, v); chk("R6 cleared", v, 0);

      // R3 report gate off, capture still on
      wr(0, 32'h1);
      pin_in[0] = 1'b1;
      idle(5);
      chk("R3 irq masked", irq_out, 0);
      rd(1, v); chk("R3 latched", v, 1);
      wr(1, 1); idle(2);
      rd(1, v); chk("R3 relatch masked", v, 1);
      pin_in[0] = 1'b0; idle(4);
      wr(1, 1); idle(2);
      rd(1, v); chk("R3 clear", v, 0);
      wr(0, 0);

      // R4 active-low level on pin1 (held low)
      wr(2, 32'h7);
      idle(3); chk("R4 low irq", irq_out, 1);
      pin_in[1] = 1'b1; idle(4);
      wr(3, 1); idle(2);
      chk("R4 low cleared irq", irq_out, 0);
      rd(3, v); chk("R4 low st", v, 0);
      wr(2, 0);

      // R5 rising edge caught while masked, reported later
      wr(4, 32'h9);
      idle(3);
      pin_in[2] = 1'b1;
      idle(5);
      chk("R5 masked irq", irq_out, 0);
      rd(5, v); chk("R5 captured", v, 1);
      wr(4, 32'hB); idle(2);
      chk("R5 reported", irq_out, 1);
      wr(5, 1); idle(3);
      chk("R5 no relatch irq", irq_out, 0);
      rd(5, v); chk("R5 no relatch", v, 0);
      wr(4, 32'hF);
      pin_in[2] = 1'b0;
      idle(5); chk("R5 falling", irq_out, 1);
      wr(5, 1); idle(3);
      chk("R5 falling cleared", irq_out, 0);
      wr(4, 0);

      // R8 configuration changes with steady input
      pin_in[3] = 1'b1; idle(4);
      wr(6, 32'h9); idle(4);
      rd(7, v); chk("R8 enable rise", v, 0);
      wr(6, 32'hD); idle(4);
      rd(7, v); chk("R8 trig change", v, 0);
      wr(6, 32'hC); wr(6, 32'hD); idle(4);
      rd(7, v); chk("R8 re-enable", v, 0);
      wr(6, 0); pin_in[3] = 1'b0; idle(3);

      // R10 register map
      wr(8, 32'hFFFF_FFFF);
      rd(8, v); chk("R10 cfg width", v, 32'hF);
      rd(9, v); chk("R10 st width", v, 0);
      wr(8, 0);
      wr(12, 32'hF);
      rd(12, v); chk("R10 oor cfg", v, 0);
      rd(13, v); chk("R10 oor st", v, 0);

      // Random phase against the reference model (R2..R10)
      for (int i = 0; i < 4000; i++) begin
         chk("R3/R9 irq model", irq_out, m_irq);
         chk("R10 rdata model", reg_rdata, m_rd);
         for (int p = 0; p < NP; p++)
            if ($urandom_range(7) == 0) pin_in[p] = ~pin_in[p];
         reg_wr    = ($urandom_range(3) == 0);
         reg_addr  = AW'($urandom_range(15));
         reg_wdata = $urandom;
         @(negedge clk);
      end
      reg_wr = 1'b0;
      finish_run();
   end

endmodule